// File: doc/BRIEF.md
# Compare-memory postincrement microsequencer

This block carries out a word compare between two memory operands, each reached through an address register that is stepped forward by two after use. A start pulse, two register indices, the program counter and the supervisor state go in. The block then runs four microsteps in a fixed order. First it fetches the source pointer. Next it reads the source word and writes back the stepped source pointer. Then it reads the destination word. Last it writes back the stepped destination pointer, updates the condition flags and fetches the next opcode word at the program counter.

The two pointer writebacks happen at different points. The source pointer is updated in the same cycle that its read starts, so it is updated even when that read faults. The destination pointer is updated only after its read has returned data. A step without a bus access takes two cycles. A step with an access takes four cycles, or more while the bus holds back its acknowledge. A word access at an odd address is never put on the bus. In its place the block raises a one-cycle abort pulse that carries the faulting address, the direction and the function code, and then it goes idle.

Top module: `cmpm_seq`

## Requirements
- R1: While and after reset the block is idle: busy, bus_req, rf_we, ccr_we, done, pc_we and addr_err are all 0.
- R2: Take cycle 1 as the first cycle after the clock edge that samples start, with bus_ack always high. Cycles 1-2 are the pointer-fetch step. Cycles 3-6 read the source word at Ay, cycles 7-10 read the destination word at Ax, and cycles 11-14 read the next opcode word at pc_in. bus_req is high in the last three cycles of each access step and low in its first cycle. done and pc_we pulse in cycle 15.
- R3: In cycle 3 rf_we writes Ay+2 into the source register. This happens even when the source read aborts.
- R4: The destination register receives Ax+2 in cycle 11, after its read has completed. If the destination read aborts, the destination register is not written.
- R5: In cycle 11 ccr_we pulses and ccr_out is {X,N,Z,V,C} (bit 4 down to bit 0) for res = wA - wB. Here wA is the word read at Ay and wB the word read at Ax. N is res[15] and Z is res==0. V is set when wA[15]!=wB[15] and res[15]!=wA[15]. C is set when wB>wA unsigned. X equals ccr_x_in. No other register receives res.
- R6: An access step whose address has bit 0 set raises addr_err for exactly its first cycle. err_addr is that address and err_read is 1. err_fc is 5 (supervisor) or 1 (user) for operand reads and 6 or 2 for the opcode fetch. bus_req stays low for that access, and the block is idle from the next cycle with no further bus cycles, writes or flag updates.
- R7: In the done cycle irc holds the word read at pc_in, and pc_we pulses with pc_wdata = pc_in+2.
- R8: If bus_ack is low in the last cycle of an access step, that step holds with bus_req high until bus_ack is seen, and the data is taken in that cycle. Every later event moves back by the same number of cycles.
- R9: When the source and destination indices are equal, the destination read uses Ay+2 and the register ends at Ay+4.
- R10: start is ignored while the block is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| start | input | 1 | begin one compare when idle |
| super_mode | input | 1 | supervisor state for function codes |
| src_idx | input | IDX_W | source address register index |
| dst_idx | input | IDX_W | destination address register index |
| pc_in | input | ADDR_W | program counter for the prefetch |
| busy | output | 1 | sequence in progress |
| done | output | 1 | one-cycle completion pulse |
| rf_raddr | output | IDX_W | register file read index |
| rf_rdata | input | ADDR_W | register file read data (combinational) |
| rf_we | output | 1 | register file write enable |
| rf_waddr | output | IDX_W | register file write index |
| rf_wdata | output | ADDR_W | register file write data |
| bus_addr | output | ADDR_W | address output register |
| bus_req | output | 1 | read strobe |
| bus_ack | input | 1 | read data valid |
| bus_rdata | input | DATA_W | read data |
| ccr_x_in | input | 1 | current extend flag |
| ccr_we | output | 1 | flag write enable |
| ccr_out | output | 5 | new flags {X,N,Z,V,C} |
| pc_we | output | 1 | program counter write enable |
| pc_wdata | output | ADDR_W | stepped program counter |
| irc | output | DATA_W | prefetched opcode word |
| addr_err | output | 1 | odd-address abort pulse |
| err_addr | output | ADDR_W | faulting address |
| err_read | output | 1 | faulting access was a read |
| err_fc | output | 3 | function code of faulting access |

## Verification
A sequencer stuck in the wrong step or with a miscounted step length shows on the ports at once. The writeback and flag pulses leave cycles 3, 11 and 15, the bus_req pattern shifts, and the bench pins each of these to an exact cycle. A pointer latched from the wrong register, or a writeback placed on the wrong side of its read, shows within one access step. It appears either as a wrong bus_addr or as a register write that is present or missing after an abort. Wrong operand capture or a wrong subtraction shows only in the flag value of cycle 11, so the bench drives operand pairs that reach every flag.

// File: rtl/cmpm_pkg.sv
package cmpm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_SRC  = 3'd2,
        ST_DST  = 3'd3,
        ST_PREF = 3'd4
    } step_e;

    localparam logic [2:0] FC_USER_DATA  = 3'd1;
    localparam logic [2:0] FC_USER_PROG  = 3'd2;
    localparam logic [2:0] FC_SUPER_DATA = 3'd5;
    localparam logic [2:0] FC_SUPER_PROG = 3'd6;

    function automatic logic [2:0] fc_code(input logic sup, input logic prog);
        if (sup) return prog ? FC_SUPER_PROG : FC_SUPER_DATA;
        return prog ? FC_USER_PROG : FC_USER_DATA;
    endfunction

endpackage

// File: rtl/cmpm_addr_unit.sv
module cmpm_addr_unit #(
    parameter int ADDR_W = 32,
    parameter int INC    = 2
) (
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] sum
);
    localparam logic [ADDR_W-1:0] INC_V = ADDR_W'(INC);

    assign sum = base + INC_V;
endmodule

// File: rtl/cmpm_flag_alu.sv
module cmpm_flag_alu #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic              f_n,
    output logic              f_z,
    output logic              f_v,
    output logic              f_c
);
    logic [DATA_W:0] diff;

    always_comb begin
        diff = {1'b0, op_a} - {1'b0, op_b};
        f_n  = diff[DATA_W-1];
        f_z  = (diff[DATA_W-1:0] == '0);
        f_v  = (op_a[DATA_W-1] != op_b[DATA_W-1]) && (diff[DATA_W-1] != op_a[DATA_W-1]);
        f_c  = diff[DATA_W];
    end
endmodule

// File: rtl/cmpm_step_timer.sv
module cmpm_step_timer #(
    parameter int PURE_CYC = 2,
    parameter int ACC_CYC  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic access,
    input  logic odd,
    input  logic bus_ack,
    output logic first,
    output logic step_end,
    output logic abort,
    output logic bus_req
);
    localparam int MAXC = (PURE_CYC > ACC_CYC) ? PURE_CYC : ACC_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] PURE_LAST = CW'(PURE_CYC - 1);
    localparam logic [CW-1:0] ACC_LAST  = CW'(ACC_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] last;

    always_comb begin
        last     = access ? ACC_LAST : PURE_LAST;
        first    = run && (cnt_q == '0);
        abort    = first && access && odd;
        bus_req  = run && access && (cnt_q != '0);
        step_end = run && (cnt_q == last) && (!access || bus_ack);
        if (!run || step_end || abort)
            cnt_d = '0;
        else if (cnt_q < last)
            cnt_d = cnt_q + 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> bus_req);
    a_r6_no_req_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> !bus_req);
endmodule

// File: rtl/cmpm_seq.sv
module cmpm_seq
    import cmpm_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 16,
    parameter int IDX_W    = 3,
    parameter int PURE_CYC = 2,
    parameter int ACC_CYC  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              super_mode,
    input  logic [IDX_W-1:0]  src_idx,
    input  logic [IDX_W-1:0]  dst_idx,
    input  logic [ADDR_W-1:0] pc_in,
    output logic              busy,
    output logic              done,
    output logic [IDX_W-1:0]  rf_raddr,
    input  logic [ADDR_W-1:0] rf_rdata,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_waddr,
    output logic [ADDR_W-1:0] rf_wdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_req,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              ccr_x_in,
    output logic              ccr_we,
    output logic [4:0]        ccr_out,
    output logic              pc_we,
    output logic [ADDR_W-1:0] pc_wdata,
    output logic [DATA_W-1:0] irc,
    output logic              addr_err,
    output logic [ADDR_W-1:0] err_addr,
    output logic              err_read,
    output logic [2:0]        err_fc
);
    localparam int INC = DATA_W / 8;

    typedef struct packed {
        step_e             st;
        logic [IDX_W-1:0]  src;
        logic [IDX_W-1:0]  dst;
        logic [ADDR_W-1:0] aob;
        logic [ADDR_W-1:0] au;
        logic [ADDR_W-1:0] wb;
        logic [DATA_W-1:0] op1;
        logic [DATA_W-1:0] op2;
        logic [DATA_W-1:0] irc;
        logic              done;
        logic              pc_we;
    } seq_t;

    seq_t q, d;

    logic              run, access, first, step_end, abort;
    logic [ADDR_W-1:0] add_in, add_out;
    logic              f_n, f_z, f_v, f_c;

    cmpm_step_timer #(.PURE_CYC(PURE_CYC), .ACC_CYC(ACC_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .access   (access),
        .odd      (q.aob[0]),
        .bus_ack  (bus_ack),
        .first    (first),
        .step_end (step_end),
        .abort    (abort),
        .bus_req  (bus_req)
    );

    cmpm_addr_unit #(.ADDR_W(ADDR_W), .INC(INC)) u_au (
        .base (add_in),
        .sum  (add_out)
    );

    cmpm_flag_alu #(.DATA_W(DATA_W)) u_alu (
        .op_a (q.op1),
        .op_b (q.op2),
        .f_n  (f_n),
        .f_z  (f_z),
        .f_v  (f_v),
        .f_c  (f_c)
    );

    always_comb begin
        run    = (q.st != ST_IDLE);
        access = (q.st == ST_SRC) || (q.st == ST_DST) || (q.st == ST_PREF);
        add_in = (q.st == ST_DST) ? pc_in : rf_rdata;

        d       = q;
        d.done  = 1'b0;
        d.pc_we = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st  = ST_ADDR;
                    d.src = src_idx;
                    d.dst = dst_idx;
                end
            end
            ST_ADDR: begin
                if (step_end) begin
                    d.aob = rf_rdata;
                    d.au  = add_out;
                    d.st  = ST_SRC;
                end
            end
            ST_SRC: begin
                if (abort) begin
                    d.st = ST_IDLE;
                end else if (step_end) begin
                    d.op1 = bus_rdata;
                    d.aob = rf_rdata;
                    d.au  = add_out;
                    d.st  = ST_DST;
                end
            end
            ST_DST: begin
                if (abort) begin
                    d.st = ST_IDLE;
                end else if (step_end) begin
                    d.op2 = bus_rdata;
                    d.wb  = q.au;
                    d.aob = pc_in;
                    d.au  = add_out;
                    d.st  = ST_PREF;
                end
            end
            ST_PREF: begin
                if (abort) begin
                    d.st = ST_IDLE;
                end else if (step_end) begin
                    d.irc   = bus_rdata;
                    d.done  = 1'b1;
                    d.pc_we = 1'b1;
                    d.st    = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        busy     = run;
        done     = q.done;
        pc_we    = q.pc_we;
        pc_wdata = q.au;
        irc      = q.irc;
        bus_addr = q.aob;
        rf_raddr = (q.st == ST_SRC) ? q.dst : q.src;

        rf_we    = first && ((q.st == ST_SRC) || (q.st == ST_PREF));
        rf_waddr = (q.st == ST_PREF) ? q.dst : q.src;
        rf_wdata = (q.st == ST_PREF) ? q.wb : q.au;

        ccr_we   = first && (q.st == ST_PREF);
        ccr_out  = {ccr_x_in, f_n, f_z, f_v, f_c};

        addr_err = abort;
        err_addr = abort ? q.aob : '0;
        err_read = abort;
        err_fc   = abort ? fc_code(super_mode, q.st == ST_PREF) : 3'd0;
    end

    a_r6_no_odd_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !bus_addr[0]);
    a_r6_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |=> (!busy && !bus_req && !rf_we && !ccr_we));
    a_r5_flags_single: assert property (@(posedge clk) disable iff (!rst_n)
        ccr_we |=> !ccr_we);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_req && !rf_we && !addr_err));
    a_r7_end_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, addr_err}));
endmodule

// File: tb/sim_cmpm_seq.sv
module sim_cmpm_seq;
    localparam int AW = 32;
    localparam int DW = 16;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          start = 1'b0, super_mode = 1'b1, ccr_x_in = 1'b0;
    logic [IW-1:0] src_idx = '0, dst_idx = '0;
    logic [AW-1:0] pc_in = 32'h0000_0400;
    logic          busy, done, rf_we, bus_req, bus_ack, ccr_we, pc_we, addr_err, err_read;
    logic [IW-1:0] rf_raddr, rf_waddr;
    logic [AW-1:0] rf_rdata, rf_wdata, bus_addr, pc_wdata, err_addr;
    logic [DW-1:0] bus_rdata, irc;
    logic [4:0]    ccr_out;
    logic [2:0]    err_fc;

    cmpm_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .super_mode(super_mode),
        .src_idx(src_idx), .dst_idx(dst_idx), .pc_in(pc_in), .busy(busy), .done(done),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .bus_addr(bus_addr), .bus_req(bus_req), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .ccr_x_in(ccr_x_in), .ccr_we(ccr_we), .ccr_out(ccr_out),
        .pc_we(pc_we), .pc_wdata(pc_wdata), .irc(irc), .addr_err(addr_err),
        .err_addr(err_addr), .err_read(err_read), .err_fc(err_fc)
    );

    // register file and memory models
    logic [AW-1:0] regs [8];
    logic          pre_we = 1'b0;
    logic [IW-1:0] pre_idx = '0;
    logic [AW-1:0] pre_val = '0;
    always @(posedge clk) begin
        if (pre_we) regs[pre_idx] <= pre_val;
        else if (rf_we) regs[rf_waddr] <= rf_wdata;
    end
    assign rf_rdata = regs[rf_raddr];

    logic [AW-1:0] ma_addr = '0, mb_addr = '0;
    logic [DW-1:0] ma_word = '0, mb_word = '0;
    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        if (a == ma_addr) return ma_word;
        if (a == mb_addr) return mb_word;
        return a[15:0] ^ 16'h5A3C;
    endfunction
    assign bus_rdata = mem_word(bus_addr);

    int wait_n = 0;
    int wctr = 0;
    always @(posedge clk) wctr <= bus_req ? wctr + 1 : 0;
    assign bus_ack = bus_req && (wctr >= wait_n);

    int n_checks = 0, n_fail = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-run records
    int            n_wr, wr_cyc[2], ccr_cyc, err_cyc, done_cyc, pcwe_cyc, req_cyc, late_busy;
    logic [IW-1:0] wr_idx[2];
    logic [AW-1:0] wr_dat[2], err_a, pcw_v;
    logic [AW-1:0] req_addr[3];
    int            n_rise;
    logic [4:0]    ccr_v;
    logic [2:0]    efc;
    logic          erd, prev_req;
    logic [DW-1:0] irc_v;

    task automatic preload(input logic [IW-1:0] i, input logic [AW-1:0] v);
        pre_we = 1'b1; pre_idx = i; pre_val = v;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic run_op(input logic [IW-1:0] s, input logic [IW-1:0] t,
                          input logic [AW-1:0] ay, input logic [AW-1:0] ax,
                          input logic [DW-1:0] wa, input logic [DW-1:0] wb,
                          input logic [AW-1:0] pc, input logic sup, input logic x,
                          input bit restart);
        preload(t, ax);
        preload(s, ay);
        ma_addr = ay; ma_word = wa;
        mb_addr = (s == t) ? ay + 2 : ax; mb_word = wb;
        pc_in = pc; super_mode = sup; ccr_x_in = x;
        src_idx = s; dst_idx = t;
        n_wr = 0; ccr_cyc = 0; err_cyc = 0; done_cyc = 0; pcwe_cyc = 0; req_cyc = 0;
        n_rise = 0; prev_req = 1'b0; late_busy = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int c = 1; c <= 40; c++) begin
            if (restart && c == 5) start = 1'b1;
            if (restart && c == 6) start = 1'b0;
            if (rf_we && n_wr < 2) begin
                wr_cyc[n_wr] = c; wr_idx[n_wr] = rf_waddr; wr_dat[n_wr] = rf_wdata; n_wr++;
            end
            if (ccr_we) begin ccr_cyc = c; ccr_v = ccr_out; end
            if (addr_err) begin err_cyc = c; err_a = err_addr; efc = err_fc; erd = err_read; end
            if (done) begin done_cyc = c; irc_v = irc; end
            if (pc_we) begin pcwe_cyc = c; pcw_v = pc_wdata; end
            if (bus_req) req_cyc++;
            if (bus_req && !prev_req && n_rise < 3) begin req_addr[n_rise] = bus_addr; n_rise++; end
            prev_req = bus_req;
            if (c >= 30 && busy) late_busy = 1;
            @(negedge clk);
        end
    endtask

    function automatic logic [4:0] exp_ccr(input logic x, input logic [DW-1:0] a, input logic [DW-1:0] b);
        logic [DW-1:0] r;
        r = a - b;
        return {x, r[DW-1], r == '0, (a[DW-1] != b[DW-1]) && (r[DW-1] != a[DW-1]), b > a};
    endfunction

    task automatic t_reset();
        chk(!busy && !bus_req && !rf_we && !ccr_we && !done && !pc_we && !addr_err,
            "R1 reset idle", {busy, bus_req, rf_we, ccr_we, done, pc_we, addr_err}, 0);
    endtask

    task automatic t_normal(input logic [DW-1:0] wa, input logic [DW-1:0] wb, input logic x, input string nm);
        run_op(3'd4, 3'd3, 32'h0000_2000, 32'h0000_3010, wa, wb, 32'h0000_0400, 1'b1, x, 1'b0);
        chk(n_wr == 2 && wr_cyc[0] == 3 && wr_idx[0] == 4 && wr_dat[0] == 32'h2002,
            {"R3 source writeback ", nm}, {wr_cyc[0][7:0], wr_dat[0]}, {8'd3, 32'h2002});
        chk(wr_cyc[1] == 11 && wr_idx[1] == 3 && wr_dat[1] == 32'h3012,
            {"R4 dest writeback ", nm}, {wr_cyc[1][7:0], wr_dat[1]}, {8'd11, 32'h3012});
        chk(ccr_cyc == 11 && ccr_v == exp_ccr(x, wa, wb),
            {"R5 flags ", nm}, {ccr_cyc[7:0], 3'b0, ccr_v}, {8'd11, 3'b0, exp_ccr(x, wa, wb)});
        chk(done_cyc == 15 && pcwe_cyc == 15 && req_cyc == 9 && n_rise == 3 &&
            req_addr[0] == 32'h2000 && req_addr[1] == 32'h3010 && req_addr[2] == 32'h400,
            {"R2 timing ", nm}, {done_cyc[7:0], req_cyc[7:0]}, {8'd15, 8'd9});
        chk(irc_v == (16'h0400 ^ 16'h5A3C) && pcw_v == 32'h402,
            {"R7 prefetch ", nm}, {irc_v, pcw_v}, {16'h0400 ^ 16'h5A3C, 32'h402});
    endtask

    task automatic t_same_reg();
        run_op(3'd2, 3'd2, 32'h0000_1000, 32'h0000_1000, 16'h0005, 16'h0005, 32'h500, 1'b1, 1'b1, 1'b0);
        chk(req_addr[1] == 32'h1002 && wr_dat[1] == 32'h1004 && regs[2] == 32'h1004,
            "R9 shared register", {req_addr[1], regs[2]}, {32'h1002, 32'h1004});
        chk(ccr_v == 5'b10100, "R5 equal operands Z", ccr_v, 5'b10100);
    endtask

    task automatic t_err_src();
        run_op(3'd1, 3'd0, 32'h0000_0A01, 32'h0000_0C00, 16'h1, 16'h2, 32'h600, 1'b1, 1'b0, 1'b0);
        chk(err_cyc == 3 && err_a == 32'hA01 && erd && efc == 3'd5,
            "R6 source odd abort", {err_cyc[7:0], efc, err_a}, {8'd3, 3'd5, 32'hA01});
        chk(n_wr == 1 && wr_dat[0] == 32'hA03 && regs[1] == 32'hA03,
            "R3 source updated despite abort", {n_wr[7:0], regs[1]}, {8'd1, 32'hA03});
        chk(req_cyc == 0 && ccr_cyc == 0 && done_cyc == 0 && !busy,
            "R6 no bus after source abort", {req_cyc[7:0], ccr_cyc[7:0]}, 0);
    endtask

    task automatic t_err_dst();
        super_mode = 1'b0;
        run_op(3'd5, 3'd6, 32'h0000_0B00, 32'h0000_0D03, 16'h1, 16'h2, 32'h600, 1'b0, 1'b0, 1'b0);
        chk(err_cyc == 7 && err_a == 32'hD03 && efc == 3'd1,
            "R6 dest odd abort user code", {err_cyc[7:0], efc, err_a}, {8'd7, 3'd1, 32'hD03});
        chk(n_wr == 1 && regs[6] == 32'hD03 && regs[5] == 32'hB02 && ccr_cyc == 0,
            "R4 dest kept after abort", {n_wr[7:0], regs[6]}, {8'd1, 32'hD03});
        chk(req_cyc == 3, "R6 only source strobes", req_cyc, 3);
    endtask

    task automatic t_err_pc();
        run_op(3'd0, 3'd7, 32'h0000_0100, 32'h0000_0200, 16'h7, 16'h3, 32'h0701, 1'b1, 1'b0, 1'b0);
        chk(err_cyc == 11 && err_a == 32'h701 && efc == 3'd6,
            "R6 prefetch odd abort", {err_cyc[7:0], efc, err_a}, {8'd11, 3'd6, 32'h701});
        chk(n_wr == 2 && regs[7] == 32'h202 && ccr_cyc == 11 && done_cyc == 0 && pcwe_cyc == 0,
            "R4 R5 writes before prefetch abort", {n_wr[7:0], regs[7]}, {8'd2, 32'h202});
    endtask

    task automatic t_wait();
        wait_n = 5;
        run_op(3'd4, 3'd3, 32'h0000_2000, 32'h0000_3010, 16'h1234, 16'h1230, 32'h400, 1'b1, 1'b0, 1'b0);
        wait_n = 0;
        chk(wr_cyc[0] == 3 && wr_cyc[1] == 17 && ccr_cyc == 17 && done_cyc == 24,
            "R8 wait states", {wr_cyc[1][7:0], done_cyc[7:0]}, {8'd17, 8'd24});
        chk(ccr_v == exp_ccr(1'b0, 16'h1234, 16'h1230) && irc_v == (16'h0400 ^ 16'h5A3C),
            "R8 data taken on ack", {ccr_v, irc_v}, {exp_ccr(1'b0, 16'h1234, 16'h1230), 16'h0400 ^ 16'h5A3C});
    endtask

    task automatic t_restart();
        run_op(3'd4, 3'd3, 32'h0000_2000, 32'h0000_3010, 16'h9, 16'h9, 32'h400, 1'b1, 1'b0, 1'b1);
        chk(n_wr == 2 && done_cyc == 15 && req_cyc == 9 && late_busy == 0,
            "R10 start ignored while busy", {n_wr[7:0], done_cyc[7:0], req_cyc[7:0]}, {8'd2, 8'd15, 8'd9});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal(16'h0050, 16'h0030, 1'b1, "pos");
        t_normal(16'h0001, 16'h0002, 1'b0, "borrow");
        t_normal(16'h8000, 16'h0001, 1'b0, "overflow");
        t_normal(16'h4242, 16'h4242, 1'b1, "equal");
        t_same_reg();
        t_err_src();
        t_err_dst();
        t_err_pc();
        t_wait();
        t_restart();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule